// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Staged Fill

This block is a small fully associative translation buffer that software manages through writes to control registers. A fill takes two steps. Software first writes a page-table entry image into a staging register. A later write of a virtual address to the tag register commits a new entry. The new entry takes its fields from the staged image and its address-space number from the current address-space register. Other control writes invalidate every entry, every entry not marked global, or the one entry that matches a given address and the current address-space number.

A lookup port translates a virtual page number to a physical page number and returns the permission and fault bits in the same cycle. A read of the staging-register select returns the entry held at one fixed slot, reformatted into the page-table image layout. A parameter selects the instruction-side variant, which stores every inserted entry with its write-enable field forced to zero. Page-table walking and fault delivery are outside this block.

Top module: `asn_tlb`

## Requirements
- R1: After reset every slot is invalid, the address-space register reads zero, every lookup misses and `ins_err` is low.
- R2: A write to select 0 loads the low 7 bits of the data into the address-space register, which select 0 reads back zero-extended.
- R3: A write to select 1 stages a page-table image and by itself changes no lookup result. A write to select 2 commits an entry whose tag is data bits [42:13], whose fields come from the staged image, and whose address-space number is the register value at the moment of the select-2 write.
- R4: If bits [6:5] of the staged image are nonzero, a select-2 write inserts nothing, and `ins_err` is high for exactly the following cycle.
- R5: A lookup hits when a valid slot's page number equals `lk_vpn` and either its address-space number equals the register or its global flag is set. In that same cycle it drives the physical page, read-enable, write-enable and fault bits of that slot.
- R6: An insert goes to the lowest-numbered invalid slot. When all slots are valid it goes to the slot named by a rotating pointer. Every insert moves the pointer to the slot after the one just written.
- R7: A write to select 3 invalidates every slot.
- R8: A write to select 4 invalidates only the slots whose global flag is clear.
- R9: A write to select 5 invalidates the slot whose page number equals data bits [42:13] and whose address-space number equals the current register. A slot with a different address-space number survives.
- R10: Selects 3 and 4 always read as zero.
- R11: Select 1 reads slot 1 in image layout: physical page at [58:32], read-enable at [11:8], write-enable at [15:12], fault-on-read at bit 1, fault-on-write at bit 2, global at bit 4, with the address-space number ORed in at [63:57].
- R12: With `INSTR_SIDE` set, every inserted entry has a zero write-enable field, whatever the staged image holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control-register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 64 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 64 | Read data (combinational) |
| ins_err | output | 1 | Refused insert, one cycle after the tag write |
| lk_vpn | input | 30 | Virtual page number to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 27 | Translated physical page |
| lk_rd_en | output | 4 | Read-enable bits of the hit slot |
| lk_wr_en | output | 4 | Write-enable bits of the hit slot |
| lk_fault_rd | output | 1 | Fault-on-read bit of the hit slot |
| lk_fault_wr | output | 1 | Fault-on-write bit of the hit slot |

## Verification
The lookup is tried with a matching page under a matching number, under a different number (which separates private entries from global ones), and with a page that is only staged and not committed. Each invalidate kind runs on a mix of global and private slots, so an over-broad clear and an under-broad clear give different results. A full fill followed by one more insert shows whether the rotating pointer is used. Freeing one slot in the middle and inserting again shows whether the invalid-first rule wins over the pointer. Staging an image with a nonzero hint field shows that a refused insert leaves the contents unchanged.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int PPN_W  = 27;
    localparam int ASN_W  = 7;
    localparam int PERM_W = 4;

    // page-table image bit positions
    localparam int IMG_PPN_LSB = 32;
    localparam int IMG_ASN_LSB = 57;
    localparam int IMG_RD_LSB  = 8;
    localparam int IMG_WR_LSB  = 12;
    localparam int IMG_FR_BIT  = 1;
    localparam int IMG_FW_BIT  = 2;
    localparam int IMG_GLB_BIT = 4;
    localparam int IMG_GH_LSB  = 5;
    localparam int IMG_GH_W    = 2;

    typedef enum logic [2:0] {
        SEL_ASN      = 3'd0,
        SEL_IMAGE    = 3'd1,
        SEL_TAG      = 3'd2,
        SEL_INV_ALL  = 3'd3,
        SEL_INV_PROC = 3'd4,
        SEL_INV_ONE  = 3'd5
    } sel_e;

    typedef struct packed {
        logic                 valid;
        logic                 glb;
        logic [ASN_W-1:0]     asn;
        logic [PPN_W-1:0]     ppn;
        logic [PERM_W-1:0]    rd_en;
        logic [PERM_W-1:0]    wr_en;
        logic                 f_rd;
        logic                 f_wr;
    } slot_t;

    function automatic slot_t image_to_slot(input logic [63:0] img,
                                            input logic [ASN_W-1:0] asn);
        slot_t s;
        s.valid = 1'b1;
        s.glb   = img[IMG_GLB_BIT];
        s.asn   = asn;
        s.ppn   = img[IMG_PPN_LSB +: PPN_W];
        s.rd_en = img[IMG_RD_LSB +: PERM_W];
        s.wr_en = img[IMG_WR_LSB +: PERM_W];
        s.f_rd  = img[IMG_FR_BIT];
        s.f_wr  = img[IMG_FW_BIT];
        return s;
    endfunction

    function automatic logic [63:0] slot_to_image(input slot_t s);
        logic [63:0] img;
        img = '0;
        img = img | (64'(s.ppn)   << IMG_PPN_LSB);
        img = img | (64'(s.rd_en) << IMG_RD_LSB);
        img = img | (64'(s.wr_en) << IMG_WR_LSB);
        img = img | (64'(s.f_rd)  << IMG_FR_BIT);
        img = img | (64'(s.f_wr)  << IMG_FW_BIT);
        img = img | (64'(s.glb)   << IMG_GLB_BIT);
        img = img | (64'(s.asn)   << IMG_ASN_LSB);
        return img;
    endfunction
endpackage

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] victim,
    output logic [IDX_W-1:0] victim_next
);
    logic             free_found;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        victim      = free_found ? free_idx : rr_ptr;
        victim_next = (victim == IDX_W'(N - 1)) ? '0 : victim + 1'b1;
    end

    // R6: an invalid slot is always chosen ahead of the pointer
    p_victim_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid != '1) |-> !valid[victim]);
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N        = 8,
    parameter int VPN_W    = 30,
    parameter bit USE_GLB  = 1'b1
) (
    input  slot_t [N-1:0]            slots,
    input  logic  [N-1:0][VPN_W-1:0] vpns,
    input  logic  [VPN_W-1:0]        key_vpn,
    input  logic  [ASN_W-1:0]        key_asn,
    output logic  [N-1:0]            match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic asn_ok;
        if (USE_GLB) begin : g_glb
            assign asn_ok = (slots[g].asn == key_asn) || slots[g].glb;
        end else begin : g_exact
            assign asn_ok = (slots[g].asn == key_asn);
        end
        assign match[g] = slots[g].valid && (vpns[g] == key_vpn) && asn_ok;
    end
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES    = 8,
    parameter int VPN_W      = 30,
    parameter int PAGE_SHIFT = 13,
    parameter int READ_SLOT  = 1,
    parameter bit INSTR_SIDE = 1'b0,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [63:0]       wr_data,
    input  logic [2:0]        rd_sel,
    output logic [63:0]       rd_data,
    output logic              ins_err,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [PERM_W-1:0] lk_rd_en,
    output logic [PERM_W-1:0] lk_wr_en,
    output logic              lk_fault_rd,
    output logic              lk_fault_wr
);
    typedef struct packed {
        slot_t [ENTRIES-1:0]            slot;
        logic  [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic  [ASN_W-1:0]              asn;
        logic  [63:0]                   image;
        logic  [63:0]                   tag;
        logic  [IDX_W-1:0]              rr;
        logic                           err;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0] valid_vec, glb_vec;
    logic [ENTRIES-1:0] lk_match, inv_match;
    logic [IDX_W-1:0]   victim, victim_next;
    logic [VPN_W-1:0]   wr_vpn;
    logic               gh_bad;
    sel_e               wsel;

    assign wsel   = sel_e'(wr_sel);
    assign wr_vpn = wr_data[PAGE_SHIFT +: VPN_W];
    assign gh_bad = s_q.image[IMG_GH_LSB +: IMG_GH_W] != '0;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vec
        assign valid_vec[g] = s_q.slot[g].valid;
        assign glb_vec[g]   = s_q.slot[g].glb;
    end

    tlb_victim #(.N(ENTRIES)) u_victim (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid       (valid_vec),
        .rr_ptr      (s_q.rr),
        .victim      (victim),
        .victim_next (victim_next)
    );

    tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .USE_GLB(1'b1)) u_cam_lookup (
        .slots   (s_q.slot),
        .vpns    (s_q.vpn),
        .key_vpn (lk_vpn),
        .key_asn (s_q.asn),
        .match   (lk_match)
    );

    tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .USE_GLB(1'b0)) u_cam_inval (
        .slots   (s_q.slot),
        .vpns    (s_q.vpn),
        .key_vpn (wr_vpn),
        .key_asn (s_q.asn),
        .match   (inv_match)
    );

    // next-state logic
    always_comb begin
        slot_t fresh;
        s_d     = s_q;
        s_d.err = 1'b0;
        fresh   = image_to_slot(s_q.image, s_q.asn);
        if (INSTR_SIDE) begin
            fresh.wr_en = '0;
        end
        if (wr_en) begin
            case (wsel)
                SEL_ASN:   s_d.asn   = wr_data[ASN_W-1:0];
                SEL_IMAGE: s_d.image = wr_data;
                SEL_TAG: begin
                    if (gh_bad) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.tag          = wr_data;
                        s_d.slot[victim] = fresh;
                        s_d.vpn[victim]  = wr_vpn;
                        s_d.rr           = victim_next;
                    end
                end
                SEL_INV_ALL: begin
                    for (int i = 0; i < ENTRIES; i++) s_d.slot[i].valid = 1'b0;
                end
                SEL_INV_PROC: begin
                    for (int i = 0; i < ENTRIES; i++)
                        if (!s_q.slot[i].glb) s_d.slot[i].valid = 1'b0;
                end
                SEL_INV_ONE: begin
                    for (int i = 0; i < ENTRIES; i++)
                        if (inv_match[i]) s_d.slot[i].valid = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // lookup: lowest matching slot wins
    always_comb begin
        slot_t pick;
        pick = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_match[i]) pick = s_q.slot[i];
        end
        lk_hit      = |lk_match;
        lk_ppn      = pick.ppn;
        lk_rd_en    = pick.rd_en;
        lk_wr_en    = pick.wr_en;
        lk_fault_rd = pick.f_rd;
        lk_fault_wr = pick.f_wr;
    end

    // register reads
    always_comb begin
        case (sel_e'(rd_sel))
            SEL_ASN:   rd_data = 64'(s_q.asn);
            SEL_IMAGE: rd_data = slot_to_image(s_q.slot[READ_SLOT]);
            SEL_TAG:   rd_data = s_q.tag;
            default:   rd_data = '0;
        endcase
    end

    assign ins_err = s_q.err;

    // R4: a refused insert leaves the valid set unchanged
    p_refused_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsel == SEL_TAG && gh_bad) |=> ($stable(valid_vec) && ins_err));
    // R7: nothing stays valid after a full clear
    p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsel == SEL_INV_ALL) |=> (valid_vec == '0));
    // R8: only global slots can survive a process clear
    p_proc_global_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsel == SEL_INV_PROC) |=> ((valid_vec & ~glb_vec) == '0));
    // R3: an accepted tag write leaves at least one valid slot
    p_commit_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsel == SEL_TAG && !gh_bad) |=> (valid_vec != '0));
    // R12: instruction-side hits never grant write permission
    p_no_write_perm_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (INSTR_SIDE && lk_hit) |-> (lk_wr_en == '0));
    // R10: clear registers read as zero
    p_clear_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_INV_ALL || rd_sel == SEL_INV_PROC) |-> (rd_data == '0));
endmodule

// File: tb/asn_tlb_bench.sv
`timescale 1ns/1ps
module asn_tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [29:0] lk_vpn = '0;
    logic [63:0] rd_data, rd_data_i;
    logic        ins_err, ins_err_i;
    logic        lk_hit, lk_hit_i;
    logic [26:0] lk_ppn, lk_ppn_i;
    logic [3:0]  lk_rd_en, lk_rd_en_i, lk_wr_en, lk_wr_en_i;
    logic        lk_fr, lk_fr_i, lk_fw, lk_fw_i;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    asn_tlb u_asn_tlb (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .ins_err(ins_err), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
        .lk_fault_rd(lk_fr), .lk_fault_wr(lk_fw)
    );

    asn_tlb #(.INSTR_SIDE(1'b1)) u_asn_tlb_ins (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data_i), .ins_err(ins_err_i), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit_i), .lk_ppn(lk_ppn_i), .lk_rd_en(lk_rd_en_i), .lk_wr_en(lk_wr_en_i),
        .lk_fault_rd(lk_fr_i), .lk_fault_wr(lk_fw_i)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_img(input logic [26:0] ppn, input logic [3:0] rd,
                                           input logic [3:0] wr, input bit fr, input bit fw,
                                           input bit g, input logic [1:0] gh);
        return (64'(ppn) << 32) | (64'(rd) << 8) | (64'(wr) << 12) |
               (64'(fr) << 1) | (64'(fw) << 2) | (64'(g) << 4) | (64'(gh) << 5);
    endfunction

    task automatic wr(input logic [2:0] sel, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic insert(input logic [29:0] vpn, input logic [63:0] img);
        wr(3'd1, img);
        wr(3'd2, 64'(vpn) << 13);
    endtask

    task automatic look(input logic [29:0] vpn);
        lk_vpn = vpn;
        #1;
    endtask

    task automatic t_reset;
        look(30'h100);
        chk("R1 hit", 64'(lk_hit), 0);
        rd_sel = 3'd0; #1;
        chk("R1 asn", rd_data, 0);
        chk("R1 err", 64'(ins_err), 0);
    endtask

    task automatic t_asn;
        wr(3'd0, 64'h1AB);
        rd_sel = 3'd0; #1;
        chk("R2 asn low bits", rd_data, 64'h2B);
    endtask

    task automatic t_fill;
        wr(3'd0, 64'd5);
        wr(3'd1, mk_img(27'h123, 4'hA, 4'h5, 1, 0, 0, 0));
        look(30'h100);
        chk("R3 staged only", 64'(lk_hit), 0);
        wr(3'd0, 64'd9);
        wr(3'd2, 64'h100 << 13);
        look(30'h100);
        chk("R3 hit", 64'(lk_hit), 1);
        chk("R3 ppn", 64'(lk_ppn), 64'h123);
        chk("R5 rd_en", 64'(lk_rd_en), 64'hA);
        chk("R5 wr_en", 64'(lk_wr_en), 64'h5);
        chk("R5 faults", {62'd0, lk_fr, lk_fw}, 64'h2);
        chk("R12 ins wr_en", 64'(lk_wr_en_i), 0);
        chk("R12 ins hit", 64'(lk_hit_i), 1);
        wr(3'd0, 64'd5);
        look(30'h100);
        chk("R3 asn at commit", 64'(lk_hit), 0);
    endtask

    task automatic t_global_image;
        insert(30'h200, mk_img(27'h456, 4'h3, 4'hC, 0, 1, 1, 0));
        rd_sel = 3'd1; #1;
        chk("R11 image", rd_data, (64'h456 << 32) | (64'h3 << 8) | (64'hC << 12) |
                                   (64'h1 << 2) | (64'h1 << 4) | (64'd5 << 57));
        wr(3'd0, 64'd7);
        look(30'h200);
        chk("R5 global other asn", 64'(lk_hit), 1);
        chk("R5 global ppn", 64'(lk_ppn), 64'h456);
    endtask

    task automatic t_refuse;
        wr(3'd1, mk_img(27'h777, 4'h1, 4'h1, 0, 0, 0, 2'b01));
        wr(3'd2, 64'h300 << 13);
        chk("R4 err pulse", 64'(ins_err), 1);
        look(30'h300);
        chk("R4 no insert", 64'(lk_hit), 0);
        @(negedge clk); #1;
        chk("R4 err one cycle", 64'(ins_err), 0);
    endtask

    task automatic t_inv_proc;
        wr(3'd0, 64'd9);
        wr(3'd4, 64'd0);
        rd_sel = 3'd4; #1;
        chk("R10 proc reads zero", rd_data, 0);
        look(30'h100);
        chk("R8 private cleared", 64'(lk_hit), 0);
        look(30'h200);
        chk("R8 global kept", 64'(lk_hit), 1);
    endtask

    task automatic t_inv_one;
        wr(3'd0, 64'd3);
        insert(30'h400, mk_img(27'h40, 4'h1, 4'h0, 0, 0, 0, 0));
        insert(30'h401, mk_img(27'h41, 4'h1, 4'h0, 0, 0, 0, 0));
        wr(3'd0, 64'd4);
        wr(3'd5, 64'h400 << 13);
        wr(3'd0, 64'd3);
        look(30'h400);
        chk("R9 other asn survives", 64'(lk_hit), 1);
        wr(3'd5, 64'h400 << 13);
        look(30'h400);
        chk("R9 target cleared", 64'(lk_hit), 0);
        look(30'h401);
        chk("R9 neighbour kept", 64'(lk_hit), 1);
    endtask

    task automatic t_inv_all;
        wr(3'd3, 64'd0);
        rd_sel = 3'd3; #1;
        chk("R10 all reads zero", rd_data, 0);
        look(30'h200);
        chk("R7 global gone", 64'(lk_hit), 0);
        look(30'h401);
        chk("R7 private gone", 64'(lk_hit), 0);
    endtask

    task automatic t_replace;
        wr(3'd0, 64'd2);
        for (int i = 0; i < 8; i++)
            insert(30'h500 + 30'(i), mk_img(27'h800 + 27'(i), 4'h1, 4'h0, 0, 0, 0, 0));
        rd_sel = 3'd1; #1;
        chk("R6 slot1 order", rd_data, (64'h801 << 32) | (64'h1 << 8) | (64'd2 << 57));
        insert(30'h600, mk_img(27'h900, 4'h1, 4'h0, 0, 0, 0, 0));
        look(30'h500);
        chk("R6 pointer victim", 64'(lk_hit), 0);
        look(30'h600);
        chk("R6 new entry", 64'(lk_ppn), 64'h900);
        wr(3'd5, 64'h503 << 13);
        insert(30'h700, mk_img(27'hA00, 4'h1, 4'h0, 0, 0, 0, 0));
        look(30'h501);
        chk("R6 free slot first", 64'(lk_hit), 1);
        look(30'h700);
        chk("R6 free slot entry", 64'(lk_ppn), 64'hA00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_asn();
        t_fill();
        t_global_image();
        t_refuse();
        t_inv_proc();
        t_inv_one();
        t_inv_all();
        t_replace();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule